// File: doc/BRIEF.md
# Bus Timeout Termination Responder

This block watches every cycle on a parallel asynchronous backplane bus from the moment the address strobe goes active. If no other slave acknowledges the cycle or signals an error before a timeout runs out, the block ends the cycle itself. With responder mode on, it ends the cycle with an acknowledge. With responder mode off and halt-on-error on, it signals a bus error instead. Either kind of termination also latches a halt flag, which stays set until it is released.

On a read that times out while responder mode and data sourcing are both on, the block first drives a stored data word onto the bus. It raises its acknowledge a fixed settling time (30 ns) later. The timeout is fixed at 4 µs while the register interface is disabled. While that interface is enabled, a 2-bit selector shortens the timeout. All bus-side signals are active-high abstractions. The transceivers that convert them to backplane levels sit outside this block.

Top module: `bus_timeout_responder`

## Requirements
- R1: During and after reset, before any bus cycle, dtack_out, berr_out, data_oe and halt are all 0, and data_out is 0.
- R2: With cfg_en = 0 the timeout is 4 µs (800 clocks at 200 MHz) whatever the value of tmo_sel. The termination output rises after the 800th rising edge that samples bus_as high, and not before.
- R3: With cfg_en = 1, tmo_sel selects the timeout: 2'b00 gives 4 µs, 2'b01 gives 3 µs, 2'b10 gives 2 µs and 2'b11 gives 1 µs (800, 600, 400 and 200 clocks).
- R4: If ext_ack or ext_err is sampled high while bus_as is high before the timeout, the block makes no termination for that cycle.
- R5: With resp_mode = 1, a timed-out cycle, read or write, is ended with dtack_out = 1. The signal stays high while either bit of bus_ds is high and falls one clock after both are low.
- R6: With resp_mode = 0 and halt_on_err = 1, a timed-out cycle is ended with berr_out = 1. The signal is held and released in the same way as dtack_out.
- R7: With resp_mode = 0 and halt_on_err = 0, a timed-out cycle produces no output at all.
- R8: On a timed-out read (bus_write = 0) with resp_mode = 1 and data_en = 1, data_oe rises first and data_out equals data_word. dtack_out follows 6 clocks (30 ns) later, and data_oe stays high until the acknowledge is released. On a write, data_oe stays 0.
- R9: data_en has no effect while resp_mode = 0: data_oe stays 0 and data_out stays 0.
- R10: A timeout termination with halt_on_err = 1 sets halt. Halt stays set after the cycle ends and is cleared one clock after halt_clr is sampled high. Halt is never set when halt_on_err = 0.
- R11: The timeout counter restarts whenever bus_as is sampled low, so a new cycle always gets the full timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 200 MHz by default |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Register interface enabled; makes tmo_sel effective |
| tmo_sel | input | 2 | Timeout code (00=4, 01=3, 10=2, 11=1 µs) |
| resp_mode | input | 1 | End unanswered cycles with an acknowledge |
| halt_on_err | input | 1 | Latch halt on timeout; with resp_mode off, signal bus error |
| data_en | input | 1 | Source data_word on timed-out reads (responder mode only) |
| halt_clr | input | 1 | Release the halt flag |
| bus_as | input | 1 | Address strobe active |
| bus_ds | input | 2 | Data strobes active |
| bus_write | input | 1 | 1 = write cycle, 0 = read cycle |
| ext_ack | input | 1 | Acknowledge driven by another slave |
| ext_err | input | 1 | Bus error driven by another slave |
| data_word | input | DATA_W | Stored word returned on timed-out reads |
| dtack_out | output | 1 | Acknowledge driven by this block |
| berr_out | output | 1 | Bus error driven by this block |
| data_oe | output | 1 | Enable for the data drivers |
| data_out | output | DATA_W | Data presented to the bus (0 when not driving) |
| halt | output | 1 | Halt flag |

## Verification
A table of eight cycles crosses the mode switches with the timeout code and the transfer direction. Each row checks that nothing happens one clock before the expected expiry and that the right output appears exactly at it, which separates the four timeout lengths and shows that tmo_sel is ignored while cfg_en is low. Rows that differ only in direction, or only in resp_mode with data_en held high, separate the data-sourcing path from the plain acknowledge and the bus-error path. Directed cycles add a foreign acknowledge halfway through the count and an address strobe that drops briefly before expiry, which tells a counter that restarts apart from one that keeps accumulating.

// File: rtl/bto_pkg.sv
package bto_pkg;

   typedef enum logic [2:0] {
      ST_ARMED,
      ST_DRIVE,
      ST_ACK,
      ST_ERR,
      ST_DONE
   } bto_state_e;

   // timeout length in microseconds for a given configuration
   function automatic logic [2:0] tmo_units(input logic cfg_on, input logic [1:0] code);
      logic [2:0] u;
      if (cfg_on) u = 3'd4 - {1'b0, code};
      else        u = 3'd4;
      return u;
   endfunction

endpackage

// File: rtl/bto_timer.sv
module bto_timer #(
   parameter int CYC_PER_US = 200,
   parameter int MAX_US     = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       cfg_en,
   input  logic [1:0] tmo_sel,
   output logic       expire
);
   import bto_pkg::*;

   localparam int CW = $clog2(MAX_US * CYC_PER_US + 1);
   localparam logic [CW-1:0] CYC = CW'(CYC_PER_US);

   logic [CW-1:0] cnt;
   logic [CW-1:0] limit;

   always_comb begin
      limit = CW'(tmo_units(cfg_en, tmo_sel)) * CYC;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt <= '0;
      end else if (cnt < limit) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign expire = run && (cnt == limit - 1'b1);

endmodule

// File: rtl/bto_term_fsm.sv
module bto_term_fsm #(
   parameter int DRIVE_CYC = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic as_on,
   input  logic ds_any,
   input  logic rd_cyc,
   input  logic ext_term,
   input  logic expire,
   input  logic resp_mode,
   input  logic halt_on_err,
   input  logic data_en,
   input  logic halt_clr,
   output logic dtack_o,
   output logic berr_o,
   output logic oe_o,
   output logic halt_o
);
   import bto_pkg::*;

   localparam bit HAS_DRV = (DRIVE_CYC > 0);

   bto_state_e state, nstate;
   logic       drv_done;
   logic       fire;
   logic       oe_q;
   logic       halt_q;

   assign fire = (state == ST_ARMED) && as_on && !ext_term && expire;

   generate
      if (HAS_DRV) begin : g_drv
         localparam int DW = $clog2(DRIVE_CYC + 1);
         logic [DW-1:0] dcnt;
         always_ff @(posedge clk) begin
            if (!rst_n || state != ST_DRIVE) dcnt <= '0;
            else                             dcnt <= dcnt + 1'b1;
         end
         assign drv_done = (state == ST_DRIVE) && (dcnt == DW'(DRIVE_CYC - 1));
      end else begin : g_nodrv
         assign drv_done = 1'b1;
      end
   endgenerate

   always_comb begin
      nstate = state;
      unique case (state)
         ST_ARMED: begin
            if (as_on && ext_term) begin
               nstate = ST_DONE;
            end else if (fire) begin
               if (resp_mode) begin
                  if (rd_cyc && data_en) nstate = HAS_DRV ? ST_DRIVE : ST_ACK;
                  else                   nstate = ST_ACK;
               end else if (halt_on_err) begin
                  nstate = ST_ERR;
               end else begin
                  nstate = ST_DONE;
               end
            end
         end
         ST_DRIVE: if (drv_done) nstate = ST_ACK;
         ST_ACK:   if (!ds_any)  nstate = ST_DONE;
         ST_ERR:   if (!ds_any)  nstate = ST_DONE;
         ST_DONE:  if (!as_on)   nstate = ST_ARMED;
         default:  nstate = ST_ARMED;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_ARMED;
         oe_q   <= 1'b0;
         halt_q <= 1'b0;
      end else begin
         state <= nstate;
         if (fire && resp_mode && rd_cyc && data_en) oe_q <= 1'b1;
         else if (nstate == ST_DONE)                 oe_q <= 1'b0;
         if (fire && halt_on_err) halt_q <= 1'b1;
         else if (halt_clr)       halt_q <= 1'b0;
      end
   end

   assign dtack_o = (state == ST_ACK);
   assign berr_o  = (state == ST_ERR);
   assign oe_o    = oe_q;
   assign halt_o  = halt_q;

endmodule

// File: rtl/bus_timeout_responder.sv
module bus_timeout_responder #(
   parameter int CLK_MHZ  = 200,
   parameter int DATA_W   = 32,
   parameter int MAX_US   = 4,
   parameter int DRIVE_NS = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_en,
   input  logic [1:0]        tmo_sel,
   input  logic              resp_mode,
   input  logic              halt_on_err,
   input  logic              data_en,
   input  logic              halt_clr,
   input  logic              bus_as,
   input  logic [1:0]        bus_ds,
   input  logic              bus_write,
   input  logic              ext_ack,
   input  logic              ext_err,
   input  logic [DATA_W-1:0] data_word,
   output logic              dtack_out,
   output logic              berr_out,
   output logic              data_oe,
   output logic [DATA_W-1:0] data_out,
   output logic              halt
);

   localparam int DRIVE_CYC = (DRIVE_NS * CLK_MHZ + 999) / 1000;

   generate
      if (CLK_MHZ < 1) begin : g_bad_clk
         $error("CLK_MHZ must be at least 1");
      end
      if (MAX_US != 4) begin : g_bad_max
         $error("MAX_US must cover the 4 us default timeout");
      end
      if (DATA_W < 1) begin : g_bad_w
         $error("DATA_W must be positive");
      end
   endgenerate

   logic expire;

   bto_timer #(
      .CYC_PER_US (CLK_MHZ),
      .MAX_US     (MAX_US)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (bus_as),
      .cfg_en  (cfg_en),
      .tmo_sel (tmo_sel),
      .expire  (expire)
   );

   bto_term_fsm #(
      .DRIVE_CYC (DRIVE_CYC)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .as_on       (bus_as),
      .ds_any      (|bus_ds),
      .rd_cyc      (!bus_write),
      .ext_term    (ext_ack | ext_err),
      .expire      (expire),
      .resp_mode   (resp_mode),
      .halt_on_err (halt_on_err),
      .data_en     (data_en),
      .halt_clr    (halt_clr),
      .dtack_o     (dtack_out),
      .berr_o      (berr_out),
      .oe_o        (data_oe),
      .halt_o      (halt)
   );

   assign data_out = data_oe ? data_word : '0;

endmodule

// File: rtl/bto_checker.sv
module bto_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_as,
   input logic [1:0] bus_ds,
   input logic       dtack_out,
   input logic       berr_out,
   input logic       data_oe,
   input logic       halt
);

   // R5 R6
   only_one_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(dtack_out && berr_out));

   // R5
   dtack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dtack_out && |bus_ds) |=> dtack_out);

   // R6
   berr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (berr_out && |bus_ds) |=> berr_out);

   // R6
   berr_needs_as_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(berr_out) |-> $past(bus_as));

   // R9
   berr_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      berr_out |-> !data_oe);

   // R8
   data_before_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_oe) |-> !dtack_out);

   // R10
   halt_with_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halt) |-> (dtack_out || berr_out || data_oe));

endmodule

bind bus_timeout_responder bto_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_as    (bus_as),
   .bus_ds    (bus_ds),
   .dtack_out (dtack_out),
   .berr_out  (berr_out),
   .data_oe   (data_oe),
   .halt      (halt)
);

// File: tb/bus_timeout_responder_tb.sv
module bus_timeout_responder_tb;

   localparam int CYC_US = 200;
   localparam int DRV    = 6;
   localparam logic [31:0] WORD = 32'hA5C3_0F96;

   // {cfg, sel[1:0], resp, hoe, den, wr, kind[1:0], drv, halt}
   // kind: 0 none, 1 acknowledge, 2 bus error
   localparam logic [10:0] VEC [8] = '{
      {1'b0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0},
      {1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0},
      {1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2, 1'b0, 1'b1},
      {1'b1, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 1'b1, 1'b1},
      {1'b1, 2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 2'd1, 1'b0, 1'b0},
      {1'b1, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 2'd2, 1'b0, 1'b1},
      {1'b1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0},
      {1'b1, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_en = 1'b0, resp_mode = 1'b0, halt_on_err = 1'b0, data_en = 1'b0;
   logic halt_clr = 1'b0, bus_as = 1'b0, bus_write = 1'b0, ext_ack = 1'b0, ext_err = 1'b0;
   logic [1:0] tmo_sel = 2'd0;
   logic [1:0] bus_ds = 2'd0;
   logic [31:0] data_word = WORD;
   logic dtack_out, berr_out, data_oe, halt;
   logic [31:0] data_out;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   bus_timeout_responder u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .tmo_sel(tmo_sel),
      .resp_mode(resp_mode), .halt_on_err(halt_on_err), .data_en(data_en),
      .halt_clr(halt_clr), .bus_as(bus_as), .bus_ds(bus_ds), .bus_write(bus_write),
      .ext_ack(ext_ack), .ext_err(ext_err), .data_word(data_word),
      .dtack_out(dtack_out), .berr_out(berr_out), .data_oe(data_oe),
      .data_out(data_out), .halt(halt)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [2:0] outs();
      return {dtack_out, berr_out, data_oe};
   endfunction

   initial begin
      repeat (1000000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      logic [10:0] v;
      int lim;
      logic [2:0] hold;
      int bad;
      repeat (4) @(negedge clk);
      // R1 reset state
      chk("R1 outputs in reset", {29'd0, outs()}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 outputs after reset", {28'd0, halt, outs()}, 32'd0);
      chk("R1 data_out after reset", data_out, 32'd0);

      for (int i = 0; i < 8; i++) begin
         v = VEC[i];
         cfg_en = v[10]; tmo_sel = v[9:8]; resp_mode = v[7];
         halt_on_err = v[6]; data_en = v[5]; bus_write = v[4];
         lim = (v[10] ? (4 - int'(v[9:8])) : 4) * CYC_US;
         bus_as = 1'b1; bus_ds = 2'b11;
         repeat (lim - 1) @(negedge clk);
         chk(v[10] ? "R3 quiet before expiry" : "R2 quiet before expiry", {29'd0, outs()}, 32'd0);
         @(negedge clk);
         case (v[3:2])
            2'd1: begin
               if (v[1]) begin
                  chk("R8 data driven first", {29'd0, outs()}, 32'd1);
                  chk("R8 data value", data_out, WORD);
                  repeat (DRV - 1) @(negedge clk);
                  chk("R8 ack still delayed", {31'd0, dtack_out}, 32'd0);
                  @(negedge clk);
                  chk("R8 ack after delay", {29'd0, outs()}, 32'd5);
                  hold = 3'b101;
               end else begin
                  chk(v[10] ? "R3 R5 ack at expiry" : "R2 R5 ack at expiry", {29'd0, outs()}, 32'd4);
                  chk("R8 no drive", data_out, 32'd0);
                  hold = 3'b100;
               end
            end
            2'd2: begin
               chk("R3 R6 berr at expiry", {29'd0, outs()}, 32'd2);
               chk("R9 no drive without responder", data_out, 32'd0);
               hold = 3'b010;
            end
            default: begin
               chk("R7 nothing at expiry", {29'd0, outs()}, 32'd0);
               hold = 3'b000;
            end
         endcase
         repeat (3) @(negedge clk);
         chk("R5 R6 R7 held while strobes active", {29'd0, outs()}, {29'd0, hold});
         bus_ds = 2'b00;
         @(negedge clk);
         chk("R5 R6 released after strobes", {29'd0, outs()}, 32'd0);
         bus_as = 1'b0;
         @(negedge clk);
         chk("R10 halt state", {31'd0, halt}, {31'd0, v[0]});
         if (v[0]) begin
            halt_clr = 1'b1;
            @(negedge clk);
            halt_clr = 1'b0;
            chk("R10 halt cleared", {31'd0, halt}, 32'd0);
         end
         @(negedge clk);
      end

      // R4 another slave acknowledges midway
      cfg_en = 1'b1; tmo_sel = 2'd3; resp_mode = 1'b1; halt_on_err = 1'b1;
      data_en = 1'b0; bus_write = 1'b0;
      bus_as = 1'b1; bus_ds = 2'b11;
      repeat (100) @(negedge clk);
      ext_ack = 1'b1;
      @(negedge clk);
      ext_ack = 1'b0;
      bad = 0;
      for (int k = 0; k < 300; k++) begin
         @(negedge clk);
         if (outs() != 3'b000) bad++;
      end
      chk("R4 no termination after foreign ack", bad, 0);
      chk("R4 no halt after foreign ack", {31'd0, halt}, 32'd0);
      bus_ds = 2'b00; bus_as = 1'b0;
      repeat (2) @(negedge clk);

      // R4 foreign bus error, then R11 restart after strobe drop
      bus_as = 1'b1; bus_ds = 2'b11;
      repeat (50) @(negedge clk);
      ext_err = 1'b1;
      @(negedge clk);
      ext_err = 1'b0;
      repeat (250) @(negedge clk);
      chk("R4 no termination after foreign error", {29'd0, outs()}, 32'd0);
      bus_as = 1'b0; bus_ds = 2'b00;
      repeat (2) @(negedge clk);

      halt_on_err = 1'b0;
      bus_as = 1'b1; bus_ds = 2'b11;
      repeat (150) @(negedge clk);
      bus_as = 1'b0;
      @(negedge clk);
      bus_as = 1'b1;
      repeat (199) @(negedge clk);
      chk("R11 count restarted", {31'd0, dtack_out}, 32'd0);
      @(negedge clk);
      chk("R11 full timeout after restart", {31'd0, dtack_out}, 32'd1);
      bus_ds = 2'b00;
      @(negedge clk);
      bus_as = 1'b0;
      @(negedge clk);
      chk("R10 no halt when halt_on_err off", {31'd0, halt}, 32'd0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule